// File: doc/BRIEF.md
# I2C Command-List Sequencer

This block runs a short program of byte-level I2C operations. Software fills a command buffer, where each word asks for an operation with an optional START, a write or a read, an optional NACK on the received byte and an optional STOP. Software then starts the list with one register write. The sequencer walks the buffer from entry 0 and hands each operation to an external bit engine through a request/done handshake. Write data comes from the buffer entry that follows the write command. Received bytes are packed into a separate read buffer.

When the list ends, or when a written byte is not acknowledged, the block sets a sticky status flag and can raise an interrupt. Software then takes the read bytes out and loads the next batch. The bit engine handles SCL/SDA timing and is outside this block. It holds `bit_done_i` high for one cycle per finished operation and reports the slave's acknowledge on `bit_ack_i`.

Top module: `i2c_cmd_seq`

Register map (word addresses with default parameters): 0 control, 1 status, 2 go, 16..31 command buffer, 32..35 read buffer. Control bits: 0 soft reset, 1 core enable, 2 master mode, 11 done-interrupt enable, 12 error-interrupt enable. Status bits: 0 bus busy, 1 list running, 2 NACK seen, 8 list done, 9 error, 20:16 command index.

## Requirements
- R1: A write of 1 to bit 0 of the go register (address 2) starts the list at entry 0, but only when control bits 1 and 2 are both set and no list is running. Otherwise the write has no effect.
- R2: Command word bits: bit 7 START, bit 6 STOP, bit 5 READ, bit 4 WRITE, bit 3 NACK after the read byte, bits 2:0 repeat count. WRITE takes precedence over READ. A word with only START set issues a START-only operation.
- R3: A write command sends the low byte of the next buffer entry, and execution then continues two entries further on.
- R4: A command runs (repeat count + 1) operations. START goes only with the first of them, and STOP and NACK only with the last.
- R5: Received bytes are stored in arrival order. Byte n goes to read word n/4 at bit offset (n mod 4)*8, and the byte count restarts at 0 on every go.
- R6: The list ends at the first entry with none of bits 7, 5 or 4 set, or at a write in the last entry, or after the last entry. Status bit 8 is then set, and irq_o goes high if control bit 11 is set.
- R7: A write operation that returns no acknowledge sets status bits 2 and 9 and stops the list without setting bit 8. irq_o goes high if control bit 12 is set.
- R8: Status bit 0 follows bus_busy_i. Bit 1 is high while a list runs. Bits 20:16 give the current command index and keep the index where the list stopped.
- R9: Writing 1 to status bit 8 or bit 9 clears that flag. irq_o is the OR of each set flag gated by its enable.
- R10: Control bit 0 soft-resets the sequencer. It clears the done, error and NACK flags and the index, and reads back as 0 once the sequencer is idle.
- R11: After rst_ni, control and status read 0 (with bus_busy_i low) and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | ADDR_W | Register write word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_raddr_i | input | ADDR_W | Register read word address |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt |
| bit_req_o | output | 1 | Operation request to the bit engine |
| bit_start_o | output | 1 | Issue START before the byte |
| bit_stop_o | output | 1 | Issue STOP after the byte |
| bit_read_o | output | 1 | Read one byte |
| bit_write_o | output | 1 | Write one byte |
| bit_nack_o | output | 1 | Answer the read byte with NACK |
| bit_wbyte_o | output | 8 | Byte to write |
| bit_done_i | input | 1 | Operation finished (one-cycle pulse) |
| bit_ack_i | input | 1 | Slave acknowledged the written byte |
| bit_rbyte_i | input | 8 | Received byte, valid with bit_done_i |
| bus_busy_i | input | 1 | Bus busy indication |

## Verification
The bench uses the default parameters: a 16-entry command buffer and a 4-word read buffer. With these values a list of sixteen single-byte reads fills the read buffer exactly. That list reaches the end-after-last-entry rule, the index value 16 and the last read-buffer lane. The small sizes also keep NACK abort, soft reset, repeat counts and the disabled-core case each within a few dozen cycles.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int CB_START = 7;
  localparam int CB_STOP  = 6;
  localparam int CB_READ  = 5;
  localparam int CB_WRITE = 4;
  localparam int CB_NACK  = 3;

  localparam int CT_SRST   = 0;
  localparam int CT_CORE   = 1;
  localparam int CT_MASTER = 2;
  localparam int CT_DONEIE = 11;
  localparam int CT_ERRIE  = 12;

  localparam int ST_BUSY = 0;
  localparam int ST_TIP  = 1;
  localparam int ST_NACK = 2;
  localparam int ST_DONE = 8;
  localparam int ST_ERR  = 9;
  localparam int ST_IDX  = 16;

  localparam int A_CTRL = 0;
  localparam int A_STAT = 1;
  localparam int A_GO   = 2;

  typedef enum logic [1:0] {SQ_IDLE, SQ_DECODE, SQ_WAIT} sq_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rd;
    logic wr;
    logic nack;
  } bit_op_t;
endpackage

// File: rtl/i2c_seq_regs.sv
module i2c_seq_regs
  import i2c_seq_pkg::*;
#(
  parameter int CMD_DEPTH = 16,
  parameter int RB_WORDS  = 4,
  parameter int ADDR_W    = 6,
  localparam int IW  = $clog2(CMD_DEPTH) + 1,
  localparam int CIW = $clog2(CMD_DEPTH),
  localparam int RBW = $clog2(RB_WORDS * 4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [31:0]       wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [31:0]       rdata_o,
  input  logic              bus_busy_i,
  input  logic              tip_i,
  input  logic [IW-1:0]     idx_i,
  input  logic              done_set_i,
  input  logic              err_set_i,
  input  logic              nack_set_i,
  input  logic              rb_we_i,
  input  logic [RBW-1:0]    rb_idx_i,
  input  logic [7:0]        rb_byte_i,
  output logic              start_o,
  output logic              srst_o,
  output logic [7:0]        cmd_cur_o,
  output logic [7:0]        cmd_nxt_o,
  output logic              irq_o
);
  localparam int CMD_BASE  = CMD_DEPTH;
  localparam int DATA_BASE = 2 * CMD_DEPTH;

  logic [31:0] cmd_mem [CMD_DEPTH];
  logic [31:0] rbuf    [RB_WORDS];
  logic srst_q, core_q, master_q, doneie_q, errie_q;
  logic done_q, err_q, nack_q;

  logic wr_ctrl, wr_stat, wr_go, wr_cmd;
  logic [CIW-1:0] cmd_widx, cmd_ridx, nxt_idx;
  logic [$clog2(RB_WORDS)-1:0] rb_ridx;
  logic [ADDR_W-1:0] cmd_woff, cmd_roff, rb_roff;

  assign wr_ctrl  = we_i && (waddr_i == ADDR_W'(A_CTRL));
  assign wr_stat  = we_i && (waddr_i == ADDR_W'(A_STAT));
  assign wr_go    = we_i && (waddr_i == ADDR_W'(A_GO));
  assign wr_cmd   = we_i && (int'(waddr_i) >= CMD_BASE) && (int'(waddr_i) < CMD_BASE + CMD_DEPTH);
  assign cmd_woff = waddr_i - ADDR_W'(CMD_BASE);
  assign cmd_widx = cmd_woff[CIW-1:0];
  assign cmd_roff = raddr_i - ADDR_W'(CMD_BASE);
  assign cmd_ridx = cmd_roff[CIW-1:0];
  assign rb_roff  = raddr_i - ADDR_W'(DATA_BASE);
  assign rb_ridx  = rb_roff[$clog2(RB_WORDS)-1:0];

  assign start_o = wr_go && wdata_i[0] && core_q && master_q && !tip_i && !srst_q;
  assign srst_o  = srst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_q <= 1'b0; core_q <= 1'b0; master_q <= 1'b0;
      doneie_q <= 1'b0; errie_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        core_q   <= wdata_i[CT_CORE];
        master_q <= wdata_i[CT_MASTER];
        doneie_q <= wdata_i[CT_DONEIE];
        errie_q  <= wdata_i[CT_ERRIE];
      end
      if (wr_ctrl && wdata_i[CT_SRST]) srst_q <= 1'b1;
      else if (srst_q && !tip_i)       srst_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0; err_q <= 1'b0; nack_q <= 1'b0;
    end else if (srst_q) begin
      done_q <= 1'b0; err_q <= 1'b0; nack_q <= 1'b0;
    end else begin
      if (done_set_i)                        done_q <= 1'b1;
      else if (wr_stat && wdata_i[ST_DONE])  done_q <= 1'b0;
      if (err_set_i)                         err_q <= 1'b1;
      else if (wr_stat && wdata_i[ST_ERR])   err_q <= 1'b0;
      if (nack_set_i)                        nack_q <= 1'b1;
      else if (start_o)                      nack_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CMD_DEPTH; i++) cmd_mem[i] <= '0;
    end else if (wr_cmd) begin
      cmd_mem[cmd_widx] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < RB_WORDS; i++) rbuf[i] <= '0;
    end else if (rb_we_i) begin
      rbuf[rb_idx_i[RBW-1:2]][{rb_idx_i[1:0], 3'b000} +: 8] <= rb_byte_i;
    end
  end

  assign nxt_idx   = idx_i[CIW-1:0] + CIW'(1);
  assign cmd_cur_o = cmd_mem[idx_i[CIW-1:0]][7:0];
  assign cmd_nxt_o = cmd_mem[nxt_idx][7:0];
  assign irq_o     = (done_q && doneie_q) || (err_q && errie_q);

  always_comb begin
    rdata_o = '0;
    if (raddr_i == ADDR_W'(A_CTRL)) begin
      rdata_o[CT_SRST]   = srst_q;
      rdata_o[CT_CORE]   = core_q;
      rdata_o[CT_MASTER] = master_q;
      rdata_o[CT_DONEIE] = doneie_q;
      rdata_o[CT_ERRIE]  = errie_q;
    end else if (raddr_i == ADDR_W'(A_STAT)) begin
      rdata_o[ST_BUSY] = bus_busy_i;
      rdata_o[ST_TIP]  = tip_i;
      rdata_o[ST_NACK] = nack_q;
      rdata_o[ST_DONE] = done_q;
      rdata_o[ST_ERR]  = err_q;
      rdata_o[ST_IDX +: IW] = idx_i;
    end else if ((int'(raddr_i) >= CMD_BASE) && (int'(raddr_i) < CMD_BASE + CMD_DEPTH)) begin
      rdata_o = cmd_mem[cmd_ridx];
    end else if ((int'(raddr_i) >= DATA_BASE) && (int'(raddr_i) < DATA_BASE + RB_WORDS)) begin
      rdata_o = rbuf[rb_ridx];
    end
  end

  assert_srst_clears_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> (!done_q && !err_q && !nack_q));
  assert_irq_needs_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (done_q || err_q));
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
#(
  parameter int CMD_DEPTH = 16,
  parameter int RB_WORDS  = 4,
  localparam int IW  = $clog2(CMD_DEPTH) + 1,
  localparam int RBW = $clog2(RB_WORDS * 4)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           srst_i,
  input  logic [7:0]     cmd_cur_i,
  input  logic [7:0]     cmd_nxt_i,
  input  logic           bit_done_i,
  input  logic           bit_ack_i,
  input  logic [7:0]     bit_rbyte_i,
  output logic           bit_req_o,
  output bit_op_t        bit_op_o,
  output logic [7:0]     bit_wbyte_o,
  output logic           tip_o,
  output logic [IW-1:0]  idx_o,
  output logic           done_set_o,
  output logic           err_set_o,
  output logic           nack_set_o,
  output logic           rb_we_o,
  output logic [RBW-1:0] rb_idx_o,
  output logic [7:0]     rb_byte_o
);
  sq_state_e state_q;
  logic [IW-1:0]  idx_q;
  logic [2:0]     rep_q;
  logic [RBW-1:0] rb_cnt_q;
  logic is_wr, is_rd, has_op, last_rep, end_list, op_fin, nacked;

  assign is_wr    = cmd_cur_i[CB_WRITE];
  assign is_rd    = cmd_cur_i[CB_READ] && !is_wr;
  assign has_op   = cmd_cur_i[CB_START] || cmd_cur_i[CB_READ] || is_wr;
  assign last_rep = (rep_q == cmd_cur_i[2:0]);
  // a write in the last entry has no data slot behind it
  assign end_list = (int'(idx_q) >= CMD_DEPTH) || !has_op ||
                    (is_wr && (int'(idx_q) == CMD_DEPTH - 1));
  assign op_fin   = (state_q == SQ_WAIT) && bit_done_i;
  assign nacked   = op_fin && is_wr && !bit_ack_i;

  assign bit_req_o      = (state_q == SQ_WAIT);
  assign bit_op_o.start = cmd_cur_i[CB_START] && (rep_q == 3'd0);
  assign bit_op_o.stop  = cmd_cur_i[CB_STOP] && last_rep;
  assign bit_op_o.rd    = is_rd;
  assign bit_op_o.wr    = is_wr;
  assign bit_op_o.nack  = cmd_cur_i[CB_NACK] && is_rd && last_rep;
  assign bit_wbyte_o    = cmd_nxt_i;

  assign tip_o      = (state_q != SQ_IDLE);
  assign idx_o      = idx_q;
  assign done_set_o = (state_q == SQ_DECODE) && !srst_i && end_list;
  assign err_set_o  = nacked && !srst_i;
  assign nack_set_o = nacked && !srst_i;
  assign rb_we_o    = op_fin && is_rd && !srst_i;
  assign rb_idx_o   = rb_cnt_q;
  assign rb_byte_o  = bit_rbyte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE; idx_q <= '0; rep_q <= '0; rb_cnt_q <= '0;
    end else if (srst_i) begin
      state_q <= SQ_IDLE; idx_q <= '0; rep_q <= '0; rb_cnt_q <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (start_i) begin
          state_q <= SQ_DECODE; idx_q <= '0; rep_q <= '0; rb_cnt_q <= '0;
        end
        SQ_DECODE: state_q <= end_list ? SQ_IDLE : SQ_WAIT;
        SQ_WAIT: if (bit_done_i) begin
          if (nacked) begin
            state_q <= SQ_IDLE;
          end else begin
            state_q <= SQ_DECODE;
            if (is_rd) rb_cnt_q <= rb_cnt_q + RBW'(1);
            if (!last_rep) rep_q <= rep_q + 3'd1;
            else begin
              rep_q <= '0;
              idx_q <= idx_q + (is_wr ? IW'(2) : IW'(1));
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assert_req_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_req_o |-> (int'(idx_q) < CMD_DEPTH));
  assert_done_ends_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_set_o |=> (!tip_o && !bit_req_o));
  assert_nack_stops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set_o |=> !tip_o);
  assert_one_outcome_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_set_o && err_set_o));
  assert_start_first_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_req_o && bit_op_o.start) |-> !bit_op_o.nack || cmd_cur_i[2:0] == 3'd0);
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
#(
  parameter int CMD_DEPTH = 16,
  parameter int RB_WORDS  = 4,
  parameter int ADDR_W    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_waddr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic [ADDR_W-1:0] reg_raddr_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic              bit_req_o,
  output logic              bit_start_o,
  output logic              bit_stop_o,
  output logic              bit_read_o,
  output logic              bit_write_o,
  output logic              bit_nack_o,
  output logic [7:0]        bit_wbyte_o,
  input  logic              bit_done_i,
  input  logic              bit_ack_i,
  input  logic [7:0]        bit_rbyte_i,
  input  logic              bus_busy_i
);
  localparam int IW  = $clog2(CMD_DEPTH) + 1;
  localparam int RBW = $clog2(RB_WORDS * 4);

  logic start, srst, tip, done_set, err_set, nack_set, rb_we;
  logic [IW-1:0]  idx;
  logic [RBW-1:0] rb_idx;
  logic [7:0]     rb_byte, cmd_cur, cmd_nxt;
  bit_op_t        op;

  i2c_seq_regs #(.CMD_DEPTH(CMD_DEPTH), .RB_WORDS(RB_WORDS), .ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .waddr_i(reg_waddr_i), .wdata_i(reg_wdata_i),
    .raddr_i(reg_raddr_i), .rdata_o(reg_rdata_o),
    .bus_busy_i, .tip_i(tip), .idx_i(idx),
    .done_set_i(done_set), .err_set_i(err_set), .nack_set_i(nack_set),
    .rb_we_i(rb_we), .rb_idx_i(rb_idx), .rb_byte_i(rb_byte),
    .start_o(start), .srst_o(srst), .cmd_cur_o(cmd_cur), .cmd_nxt_o(cmd_nxt),
    .irq_o
  );

  i2c_seq_fsm #(.CMD_DEPTH(CMD_DEPTH), .RB_WORDS(RB_WORDS)) i_fsm (
    .clk_i, .rst_ni,
    .start_i(start), .srst_i(srst), .cmd_cur_i(cmd_cur), .cmd_nxt_i(cmd_nxt),
    .bit_done_i, .bit_ack_i, .bit_rbyte_i,
    .bit_req_o, .bit_op_o(op), .bit_wbyte_o,
    .tip_o(tip), .idx_o(idx),
    .done_set_o(done_set), .err_set_o(err_set), .nack_set_o(nack_set),
    .rb_we_o(rb_we), .rb_idx_o(rb_idx), .rb_byte_o(rb_byte)
  );

  assign bit_start_o = op.start;
  assign bit_stop_o  = op.stop;
  assign bit_read_o  = op.rd;
  assign bit_write_o = op.wr;
  assign bit_nack_o  = op.nack;
endmodule

// File: tb/test_i2c_cmd_seq.sv
module test_i2c_cmd_seq;
  localparam int AW = 6;
  localparam int CB = 16;
  localparam int DB = 32;
  localparam int LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [AW-1:0] waddr = '0, raddr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, req, o_start, o_stop, o_rd, o_wr, o_nack;
  logic [7:0] wbyte;
  logic done = 1'b0, ack = 1'b1, busy = 1'b0;
  logic [7:0] rbyte = '0;

  int checks = 0, fails = 0;
  int op_n = 0, rx_n = 0, nack_at = -1;
  bit finished = 1'b0;

  typedef struct packed { logic [4:0] op; logic [7:0] wb; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  i2c_cmd_seq i_i2c_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
    .reg_raddr_i(raddr), .reg_rdata_o(rdata), .irq_o(irq),
    .bit_req_o(req), .bit_start_o(o_start), .bit_stop_o(o_stop),
    .bit_read_o(o_rd), .bit_write_o(o_wr), .bit_nack_o(o_nack),
    .bit_wbyte_o(wbyte), .bit_done_i(done), .bit_ack_i(ack),
    .bit_rbyte_i(rbyte), .bus_busy_i(busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; waddr = AW'(a); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); raddr = AW'(a); #1 d = rdata;
  endtask

  // op bits: start, stop, rd, wr, nack
  task automatic push(input logic s, input logic p, input logic r, input logic w,
                      input logic n, input logic [7:0] b);
    exp_q.push_back({s, p, r, w, n, b});
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!irq && n < 500) begin @(negedge clk); n++; end
    chk(irq == 1'b1, tag, 32'(irq), 32'd1);
  endtask

  // bit engine model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (req) begin
        logic [4:0] got;
        got = {o_start, o_stop, o_rd, o_wr, o_nack};
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected operation", 32'(got), 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(got == e.op, "R2 R4 operation flags", 32'(got), 32'(e.op));
          if (e.op[1]) chk(wbyte == e.wb, "R3 write byte", 32'(wbyte), 32'(e.wb));
        end
        repeat (LAT) @(negedge clk);
        ack = (op_n != nack_at);
        rbyte = 8'h30 + 8'(rx_n);
        if (o_rd) rx_n++;
        op_n++;
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(0, v); chk(v == 0, "R11 control", v, 0);
    rd(1, v); chk(v == 0, "R11 status", v, 0);
    chk(irq == 1'b0, "R11 irq", 32'(irq), 0);

    // R8 busy mirror
    busy = 1'b1; rd(1, v); chk(v[0] == 1'b1, "R8 busy bit", v, 32'h1);
    busy = 1'b0;

    // R1 ignored while core disabled
    wr(0, 32'h0000_1804);
    wr(CB, 32'h90); wr(CB + 1, 32'h50); wr(CB + 2, 32'h0);
    wr(2, 32'h1);
    repeat (20) @(negedge clk);
    rd(1, v); chk(v == 0, "R1 go ignored without core enable", v, 0);

    // enable core, master, both interrupts
    wr(0, 32'h0000_1806);

    // write list: R1 R3 R6
    wr(CB + 2, 32'h10); wr(CB + 3, 32'hC3);
    wr(CB + 4, 32'h50); wr(CB + 5, 32'h5A);
    wr(CB + 6, 32'h00);
    push(1, 0, 0, 1, 0, 8'h50);
    push(0, 0, 0, 1, 0, 8'hC3);
    push(0, 1, 0, 1, 0, 8'h5A);
    wr(2, 32'h1);
    wait_irq("R6 done interrupt");
    rd(1, v); chk(v == 32'h0006_0100, "R6 R8 status after write list", v, 32'h0006_0100);
    chk(exp_q.size() == 0, "R1 all operations issued", 32'(exp_q.size()), 0);

    // R9 write-one-to-clear
    wr(1, 32'h100);
    rd(1, v); chk(v[8] == 1'b0, "R9 done cleared", v, 32'h0006_0000);
    chk(irq == 1'b0, "R9 irq low", 32'(irq), 0);

    // read list with repeat: R4 R5
    base = rx_n;
    wr(CB, 32'h90); wr(CB + 1, 32'hA1);
    wr(CB + 2, 32'h22); wr(CB + 3, 32'h68); wr(CB + 4, 32'h00);
    push(1, 0, 0, 1, 0, 8'hA1);
    push(0, 0, 1, 0, 0, 8'h0);
    push(0, 0, 1, 0, 0, 8'h0);
    push(0, 0, 1, 0, 0, 8'h0);
    push(0, 1, 1, 0, 1, 8'h0);
    wr(2, 32'h1);
    wait_irq("R6 read list done");
    chk(exp_q.size() == 0, "R4 repeat count", 32'(exp_q.size()), 0);
    begin
      logic [31:0] e;
      e = {8'h30 + 8'(base + 3), 8'h30 + 8'(base + 2), 8'h30 + 8'(base + 1), 8'h30 + 8'(base)};
      rd(DB, v); chk(v == e, "R5 byte packing", v, e);
    end
    wr(1, 32'h100);

    // NACK on second write: R7 R8
    wr(CB, 32'h90); wr(CB + 1, 32'hA0);
    wr(CB + 2, 32'h10); wr(CB + 3, 32'h11);
    wr(CB + 4, 32'h50); wr(CB + 5, 32'h22); wr(CB + 6, 32'h00);
    nack_at = op_n + 1;
    push(1, 0, 0, 1, 0, 8'hA0);
    push(0, 0, 0, 1, 0, 8'h11);
    wr(2, 32'h1);
    wait_irq("R7 error interrupt");
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R7 stopped after NACK", 32'(exp_q.size()), 0);
    rd(1, v); chk(v == 32'h0002_0204, "R7 R8 status after NACK", v, 32'h0002_0204);

    // R10 soft reset
    wr(0, 32'h0000_1807);
    repeat (3) @(negedge clk);
    rd(0, v); chk(v == 32'h0000_1806, "R10 reset bit self-clears", v, 32'h0000_1806);
    rd(1, v); chk(v == 0, "R10 flags cleared", v, 0);
    chk(irq == 1'b0, "R10 irq low", 32'(irq), 0);

    // full buffer of reads: R6 end after last entry, R5 last lane
    base = rx_n;
    for (int i = 0; i < CB; i++) begin
      wr(CB + i, 32'h20);
      push(0, 0, 1, 0, 0, 8'h0);
    end
    wr(2, 32'h1);
    wait_irq("R6 full list done");
    chk(exp_q.size() == 0, "R6 sixteen reads", 32'(exp_q.size()), 0);
    rd(1, v); chk(v == 32'h0010_0100, "R8 index after last entry", v, 32'h0010_0100);
    begin
      logic [31:0] e;
      e = {8'h30 + 8'(base + 15), 8'h30 + 8'(base + 14), 8'h30 + 8'(base + 13), 8'h30 + 8'(base + 12)};
      rd(DB + 3, v); chk(v == e, "R5 last read word", v, e);
      e = {8'h30 + 8'(base + 3), 8'h30 + 8'(base + 2), 8'h30 + 8'(base + 1), 8'h30 + 8'(base)};
      rd(DB, v); chk(v == e, "R5 first read word restart", v, e);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule